// File: doc/BRIEF.md
# Byte-Parity Latched/Registered Bus Transceiver

This block joins a 16-bit A bus to a 16-bit B bus through two independent one-way storage stages, one for each direction. Every byte travels with its own parity bit, so each stage holds 18 bits. A stage is transparent while its latch-enable is high. It freezes its contents when latch-enable falls. While latch-enable stays low it loads on each rising edge of its own clock. Pads are modelled as a data-out plus an active-high drive-enable.

Toward B, the block either computes the two parity bits from the A data, or passes the incoming A parity through and checks it. Toward A, it always passes B parity through and checks it. One odd/even select serves both directions. Each direction raises a single error flag when either of its two bytes fails the parity rule. The flag is modelled as the active-high enable of an open-drain pull-down, so several flags can be wired together. A flag is silent whenever its direction's outputs are disabled, which lets the system hide glitches while the stage is transparent.

Top module: `bpar_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_dout` equals `a_din` in the same cycle. While `le_ba` is high, `a_dout` equals `b_din` and `a_pout` equals `b_pin`. In check mode (`gen_sel`=0), `b_pout` equals `a_pin` while `le_ab` is high.
- R2: While a direction's latch-enable is low, its stage loads its input on the rising edge of that direction's clock. Its outputs then keep that value until the next such edge.
- R3: When latch-enable falls, the stage holds the value it had just before the fall. Later input changes have no effect until the next rising clock edge.
- R4: Parity groups are defined as follows:
  - Byte 0 is data bits 7:0, and its parity bit is bit 0 of the parity field.
  - Byte 1 is data bits 15:8, and its parity bit is bit 1.
  - When `odd_sel`=1, each valid 9-bit group (byte plus its parity bit) holds an odd number of ones. When `odd_sel`=0, it holds an even number.
  - With `gen_sel`=1, the parity bits stored toward B are computed from `a_din` under this rule.
- R5: With `gen_sel`=0 and `oe_ab_n`=0, `b_err_pd` is 1 exactly when either group held by the A-to-B stage breaks the rule for the current `odd_sel`. With `gen_sel`=1, `b_err_pd` stays 0.
- R6: The B-to-A direction never generates parity: `a_pout` always carries the stored `b_pin`. With `oe_ba_n`=0, `a_err_pd` is 1 exactly when either group held by the B-to-A stage breaks the rule for the current `odd_sel`.
- R7: The output-enables are active low. When `oe_ab_n`=1, `b_oe` is 0 and `b_err_pd` is 0. When `oe_ba_n`=1, `a_oe` is 0 and `a_err_pd` is 0. When an output-enable is 0, the matching drive-enable is 1.
- R8: The A-to-B controls and data (`le_ab`, `clk_ab`, `oe_ab_n`, `gen_sel`, `a_din`, `a_pin`) have no effect on the B-to-A outputs. `odd_sel` is shared and changes the checking in both directions.
- R9: While `rst_n` is low, both stages are cleared to zero. With latch-enables low, the data and parity outputs read 0 and stay 0 across clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both stages |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity, both directions |
| gen_sel | input | 1 | 1 = generate parity toward B, 0 = pass and check |
| clk_ab | input | 1 | A-to-B stage clock |
| le_ab | input | 1 | A-to-B latch-enable, high = transparent |
| oe_ab_n | input | 1 | A-to-B output-enable, active low |
| clk_ba | input | 1 | B-to-A stage clock |
| le_ba | input | 1 | B-to-A latch-enable, high = transparent |
| oe_ba_n | input | 1 | B-to-A output-enable, active low |
| a_din | input | 16 | Data received from the A pads |
| a_pin | input | 2 | Parity received from the A pads |
| a_dout | output | 16 | Data driven onto the A pads |
| a_pout | output | 2 | Parity driven onto the A pads |
| a_oe | output | 1 | Drive-enable for A data and parity |
| a_err_pd | output | 1 | Pull-down enable of the A-side error flag (B-to-A check) |
| b_din | input | 16 | Data received from the B pads |
| b_pin | input | 2 | Parity received from the B pads |
| b_dout | output | 16 | Data driven onto the B pads |
| b_pout | output | 2 | Parity driven onto the B pads |
| b_oe | output | 1 | Drive-enable for B data and parity |
| b_err_pd | output | 1 | Pull-down enable of the B-side error flag (A-to-B check) |

## Verification
The bench sweeps every byte value under both parity senses in generate mode. A design that swapped the odd and even sense, or tied a parity bit to the wrong byte, would show wrong `b_pout` values there. It then injects every pattern of corrupted parity bits in both directions with the output-enables on and off. This catches a flag that ignores one byte, that is not gated, or that stays active in generate mode. The clocked tests drop latch-enable between edges and then change the input. A stage that keeps tracking its input, or that reverts to an older clocked value, would give the wrong held data. A final test disturbs every A-to-B control while the B-to-A stage holds data, and flips the shared parity select. This exposes any cross-coupling between the directions.

// File: rtl/bpar_xcvr.sv
module bpar_xcvr #(
  parameter int BYTES = 2,
  localparam int DW = BYTES * 8,
  localparam int SW = DW + BYTES
) (
  input  logic             rst_n,
  input  logic             odd_sel,
  input  logic             gen_sel,
  input  logic             clk_ab,
  input  logic             le_ab,
  input  logic             oe_ab_n,
  input  logic             clk_ba,
  input  logic             le_ba,
  input  logic             oe_ba_n,
  input  logic [DW-1:0]    a_din,
  input  logic [BYTES-1:0] a_pin,
  output logic [DW-1:0]    a_dout,
  output logic [BYTES-1:0] a_pout,
  output logic             a_oe,
  output logic             a_err_pd,
  input  logic [DW-1:0]    b_din,
  input  logic [BYTES-1:0] b_pin,
  output logic [DW-1:0]    b_dout,
  output logic [BYTES-1:0] b_pout,
  output logic             b_oe,
  output logic             b_err_pd
);

  function automatic logic [BYTES-1:0] gen_par(input logic [DW-1:0] d, input logic odd);
    for (int i = 0; i < BYTES; i++) gen_par[i] = (^d[8*i +: 8]) ^ odd;
  endfunction

  function automatic logic grp_err(input logic [SW-1:0] w, input logic odd);
    grp_err = 1'b0;
    for (int i = 0; i < BYTES; i++)
      grp_err = grp_err | (((^w[8*i +: 8]) ^ w[DW+i]) != odd);
  endfunction

  logic [1:0]    le_v, clk_v;
  logic [SW-1:0] din_v [2];
  logic [SW-1:0] y_v   [2];

  assign le_v     = {le_ba, le_ab};
  assign clk_v    = {clk_ba, clk_ab};
  assign din_v[0] = {(gen_sel ? gen_par(a_din, odd_sel) : a_pin), a_din};
  assign din_v[1] = {b_pin, b_din};

  for (genvar g = 0; g < 2; g++) begin : g_stage
    logic [SW-1:0] f_q, l_q;
    logic          ph_q, ph_l;

    always_ff @(posedge clk_v[g] or negedge rst_n) begin
      if (!rst_n) begin
        f_q  <= '0;
        ph_q <= 1'b0;
      end else if (!le_v[g]) begin
        f_q  <= din_v[g];
        ph_q <= ~ph_l;
      end
    end

    always_latch begin
      if (!rst_n) begin
        l_q  = '0;
        ph_l = 1'b0;
      end else if (le_v[g]) begin
        l_q  = din_v[g];
        ph_l = ph_q;
      end
    end

    assign y_v[g] = le_v[g] ? din_v[g] : ((ph_q == ph_l) ? l_q : f_q);
  end

  assign b_dout   = y_v[0][DW-1:0];
  assign b_pout   = y_v[0][SW-1:DW];
  assign b_oe     = ~oe_ab_n;
  assign b_err_pd = ~oe_ab_n & ~gen_sel & grp_err(y_v[0], odd_sel);

  assign a_dout   = y_v[1][DW-1:0];
  assign a_pout   = y_v[1][SW-1:DW];
  assign a_oe     = ~oe_ba_n;
  assign a_err_pd = ~oe_ba_n & grp_err(y_v[1], odd_sel);

endmodule

// File: rtl/bpar_xcvr_chk.sv
module bpar_xcvr_chk #(
  parameter int BYTES = 2,
  localparam int DW = BYTES * 8
) (
  input logic             rst_n,
  input logic             odd_sel,
  input logic             gen_sel,
  input logic             clk_ab,
  input logic             le_ab,
  input logic             oe_ab_n,
  input logic             clk_ba,
  input logic             le_ba,
  input logic             oe_ba_n,
  input logic [DW-1:0]    a_din,
  input logic [BYTES-1:0] a_pin,
  input logic [DW-1:0]    a_dout,
  input logic [BYTES-1:0] a_pout,
  input logic             a_oe,
  input logic             a_err_pd,
  input logic [DW-1:0]    b_din,
  input logic [BYTES-1:0] b_pin,
  input logic [DW-1:0]    b_dout,
  input logic [BYTES-1:0] b_pout,
  input logic             b_oe,
  input logic             b_err_pd
);

  function automatic logic groups_ok(input logic [DW-1:0] d, input logic [BYTES-1:0] p, input logic odd);
    groups_ok = 1'b1;
    for (int i = 0; i < BYTES; i++)
      if (($countones({p[i], d[8*i +: 8]}) % 2) != int'(odd)) groups_ok = 1'b0;
  endfunction

  AST_XPAR_AB: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (le_ab && !gen_sel) |-> (b_dout == a_din && b_pout == a_pin)); // R1
  AST_XPAR_BA: assert property (@(posedge clk_ba) disable iff (!rst_n)
    le_ba |-> (a_dout == b_din && a_pout == b_pin)); // R6
  AST_HOLD_AB: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!le_ab && $past(!le_ab) && $past(rst_n)) |-> (b_dout == $past(a_din))); // R2
  AST_HOLD_BA: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!le_ba && $past(!le_ba) && $past(rst_n)) |-> (a_dout == $past(b_din) && a_pout == $past(b_pin))); // R2
  AST_GEN_PAR: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (le_ab && gen_sel) |-> groups_ok(b_dout, b_pout, odd_sel)); // R4
  AST_GEN_NOFLAG: assert property (@(posedge clk_ab) disable iff (!rst_n)
    gen_sel |-> !b_err_pd); // R5
  AST_B_QUIET: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_ab_n |-> (!b_oe && !b_err_pd)); // R7
  AST_A_QUIET: assert property (@(posedge clk_ba) disable iff (!rst_n)
    oe_ba_n |-> (!a_oe && !a_err_pd)); // R7

endmodule

bind bpar_xcvr bpar_xcvr_chk #(.BYTES(BYTES)) u_chk (
  .rst_n(rst_n), .odd_sel(odd_sel), .gen_sel(gen_sel),
  .clk_ab(clk_ab), .le_ab(le_ab), .oe_ab_n(oe_ab_n),
  .clk_ba(clk_ba), .le_ba(le_ba), .oe_ba_n(oe_ba_n),
  .a_din(a_din), .a_pin(a_pin), .a_dout(a_dout), .a_pout(a_pout),
  .a_oe(a_oe), .a_err_pd(a_err_pd),
  .b_din(b_din), .b_pin(b_pin), .b_dout(b_dout), .b_pout(b_pout),
  .b_oe(b_oe), .b_err_pd(b_err_pd)
);

// File: tb/bpar_xcvr_tb.sv
`timescale 1ns/1ps
module bpar_xcvr_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, odd_sel, gen_sel, le_ab, oe_ab_n, le_ba, oe_ba_n;
  logic [15:0] a_din, b_din, a_dout, b_dout;
  logic [1:0]  a_pin, b_pin, a_pout, b_pout;
  logic a_oe, b_oe, a_err_pd, b_err_pd;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bpar_xcvr u_dut (
    .rst_n(rst_n), .odd_sel(odd_sel), .gen_sel(gen_sel),
    .clk_ab(clk), .le_ab(le_ab), .oe_ab_n(oe_ab_n),
    .clk_ba(clk), .le_ba(le_ba), .oe_ba_n(oe_ba_n),
    .a_din(a_din), .a_pin(a_pin), .a_dout(a_dout), .a_pout(a_pout),
    .a_oe(a_oe), .a_err_pd(a_err_pd),
    .b_din(b_din), .b_pin(b_pin), .b_dout(b_dout), .b_pout(b_pout),
    .b_oe(b_oe), .b_err_pd(b_err_pd)
  );

  function automatic logic [1:0] xpar(input logic [15:0] d, input logic odd);
    for (int i = 0; i < 2; i++)
      xpar[i] = (($countones(d[8*i +: 8]) % 2) == 0) ? odd : !odd;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; odd_sel = 0; gen_sel = 0; le_ab = 0; le_ba = 0;
    oe_ab_n = 1; oe_ba_n = 1; a_din = 16'hFFFF; a_pin = 2'b11; b_din = 16'hFFFF; b_pin = 2'b11;
    edge1(); edge1();
    // R9 reset clears, R7 quiet while disabled
    chk("R9 b_dout", b_dout, 0);
    chk("R9 a_dout", a_dout, 0);
    chk("R9 pout", {a_pout, b_pout}, 0);
    chk("R7 oe off", {a_oe, b_oe, a_err_pd, b_err_pd}, 0);
    rst_n = 1;
    edge1();

    // R4/R1 generate sweep, transparent
    le_ab = 1; gen_sel = 1; oe_ab_n = 0;
    for (int o = 0; o < 2; o++)
      for (int v = 0; v < 256; v++) begin
        odd_sel = o[0];
        a_din = {v[7:0] ^ 8'hC3, v[7:0]};
        a_pin = ~xpar(a_din, odd_sel);
        #1;
        chk("R1 b_dout", b_dout, a_din);
        chk("R4 b_pout", b_pout, xpar(a_din, odd_sel));
        chk("R5 gen no flag", b_err_pd, 0);
      end

    // R5/R7 A-to-B check sweep
    gen_sel = 0;
    for (int o = 0; o < 2; o++)
      for (int e = 0; e < 2; e++)
        for (int pe = 0; pe < 4; pe++)
          for (int v = 0; v < 4; v++) begin
            odd_sel = o[0]; oe_ab_n = e[0];
            a_din = 16'(v * 16'h1357 + 16'h0F01);
            a_pin = xpar(a_din, odd_sel) ^ pe[1:0];
            #1;
            chk("R1 b_pout pass", b_pout, a_pin);
            chk("R5 b_err_pd", b_err_pd, (!e[0] && pe != 0));
            chk("R7 b_oe", b_oe, !e[0]);
          end

    // R6/R7 B-to-A check sweep, generate mode must not touch it
    le_ba = 1; gen_sel = 1;
    for (int o = 0; o < 2; o++)
      for (int e = 0; e < 2; e++)
        for (int pe = 0; pe < 4; pe++)
          for (int v = 0; v < 4; v++) begin
            odd_sel = o[0]; oe_ba_n = e[0];
            b_din = 16'(v * 16'h2A63 + 16'h8000);
            b_pin = xpar(b_din, odd_sel) ^ pe[1:0];
            #1;
            chk("R1 a_dout", a_dout, b_din);
            chk("R6 a_pout", a_pout, b_pin);
            chk("R6 a_err_pd", a_err_pd, (!e[0] && pe != 0));
            chk("R7 a_oe", a_oe, !e[0]);
          end

    // R2 clocked mode
    edge1();
    gen_sel = 0; odd_sel = 1; oe_ab_n = 0; oe_ba_n = 0;
    le_ab = 0; le_ba = 0;
    a_din = 16'h1234; a_pin = xpar(16'h1234, 1) ^ 2'b10;
    b_din = 16'hABCD; b_pin = xpar(16'hABCD, 1);
    edge1();
    chk("R2 b_dout load", b_dout, 16'h1234);
    chk("R2 a_dout load", a_dout, 16'hABCD);
    chk("R5 stored bad parity", b_err_pd, 1);
    chk("R6 stored good parity", a_err_pd, 0);
    a_din = 16'h5555; a_pin = xpar(16'h5555, 1);
    #3;
    chk("R2 hold between edges", b_dout, 16'h1234);
    edge1();
    chk("R2 next load", b_dout, 16'h5555);
    chk("R5 flag clears", b_err_pd, 0);

    // R3 latched mode
    le_ab = 1; a_din = 16'h0F0F; a_pin = xpar(16'h0F0F, 1);
    edge1();
    le_ab = 0; #1;
    a_din = 16'hF0F0; a_pin = xpar(16'hF0F0, 1); #1;
    chk("R3 latched hold", b_dout, 16'h0F0F);
    chk("R3 latched parity", b_pout, xpar(16'h0F0F, 1));
    edge1();
    chk("R3 edge after latch", b_dout, 16'hF0F0);

    // R8 independence and shared odd select
    for (int k = 0; k < 6; k++) begin
      le_ab = k[0]; gen_sel = k[1]; oe_ab_n = k[2];
      a_din = 16'(k * 16'h1111); a_pin = k[1:0];
      edge1();
      chk("R8 a_dout untouched", a_dout, 16'hABCD);
      chk("R8 a_pout untouched", a_pout, xpar(16'hABCD, 1));
      chk("R8 a_err untouched", a_err_pd, 0);
    end
    le_ab = 0; gen_sel = 0; oe_ab_n = 0;
    a_din = 16'h00FF; a_pin = xpar(16'h00FF, 1);
    edge1();
    chk("R8 b good under odd", b_err_pd, 0);
    odd_sel = 0; #1;
    chk("R8 shared odd A side", a_err_pd, 1);
    chk("R8 shared odd B side", b_err_pd, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule